// File: doc/BRIEF.md
# Idle-Aware Transactional Clock Gate Controller

This block decides, for a set of transactional clocks, whether each one runs. Software owns one hint bit per clock in a writable register. A hint of 1 asks for the clock and is granted on the next edge. A hint of 0 is only a request to stop. The clock is switched off when the block it feeds reports idle. If that block is busy, the clock keeps running until the idle report arrives.

A low-power input overrides every hint and stops all clocks. The enables are registered logic outputs meant to drive external gating cells. Because a hint of 0 does not say whether a clock actually stopped, a second, read-only register location returns the live enable state of every clock.

The register port is a single-cycle write strobe with an address and data word, plus a combinational read path on the same address.

Top module: `tcg_ctrl`

## Requirements
- R1: While reset is asserted, every hint bit and every enable output is 1, and the status location reads all clock bits as 1.
- R2: With low power off, a clock whose hint bit is 1 has its enable at 1 after the next rising edge, whatever its idle input is.
- R3: With low power off, a clock whose hint bit is 0 and whose idle input is 1 has its enable at 0 after the next rising edge.
- R4: With low power off, a running clock whose hint bit is 0 and whose idle input is 0 stays enabled.
- R5: A clock held on by a busy block turns off on the edge that first samples its idle input high while its hint is still 0.
- R6: A disabled clock whose hint bit is 0 stays disabled when its idle input falls again, until its hint returns to 1.
- R7: When low power is 1 at a rising edge, every enable is 0 after that edge, whatever the hints and idle inputs are.
- R8: A read of address 1 returns the enable outputs in bits N-1:0 in the same cycle, with bit i for clock i, and 0 in all higher bits.
- R9: A write to address 0 loads bits N-1:0 of the write data into the hint bits, with bit i for clock i, and reading address 0 returns them with higher bits 0. Writes to any other address change no hint. Reads of addresses other than 0 and 1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (2) | Register address for both read and write |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Register read data, combinational on reg_addr |
| low_power | input | 1 | Forces every clock off while high |
| idle_in | input | NUM_CLK (4) | Per-clock idle report from the served block |
| clk_en | output | NUM_CLK (4) | Registered per-clock enable |

## Verification
A wrong enable bit appears on clk_en one edge after the hint, idle or low-power input that caused it. The same bit appears on the status read in that cycle, so the two must always agree. A hint register corrupted by a misdecoded write shows up right away on a read of address 0. It also shows up one edge later on the enables if the hint bit went low with idle high. A cell that fails to hold its off state is caught when idle falls back to 0 and the enable rises again at the next edge.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
   localparam int unsigned TCG_DEF_CLKS   = 4;
   localparam int unsigned TCG_DEF_DATA_W = 32;
   localparam int unsigned TCG_DEF_ADDR_W = 2;
   localparam int unsigned TCG_HINT_ADDR  = 0;
   localparam int unsigned TCG_STAT_ADDR  = 1;

   typedef enum logic [1:0] {
      TCG_SEL_HINT = 2'd0,
      TCG_SEL_STAT = 2'd1,
      TCG_SEL_NONE = 2'd2
   } tcg_sel_e;
endpackage

// File: rtl/tcg_hint_reg.sv
module tcg_hint_reg #(
   parameter int unsigned NUM_CLK = 4,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_hit,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_CLK-1:0] hint_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hint_q <= '1;
      end else if (wr_hit) begin
         hint_q <= wdata[NUM_CLK-1:0];
      end
   end
endmodule

// File: rtl/tcg_gate_cell.sv
module tcg_gate_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic low_power,
   input  logic hint,
   input  logic idle,
   output logic en_q
);
   logic en_d;

   always_comb begin
      if (low_power) begin
         en_d = 1'b0;
      end else if (hint) begin
         en_d = 1'b1;
      end else begin
         en_d = en_q & ~idle;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b1;
      end else begin
         en_q <= en_d;
      end
   end
endmodule

// File: rtl/tcg_read_mux.sv
module tcg_read_mux
   import tcg_pkg::*;
#(
   parameter int unsigned NUM_CLK = 4,
   parameter int unsigned DATA_W  = 32
) (
   input  tcg_sel_e           sel,
   input  logic [NUM_CLK-1:0] hint,
   input  logic [NUM_CLK-1:0] en,
   output logic [DATA_W-1:0]  rdata
);
   logic [NUM_CLK-1:0] picked;

   always_comb begin
      case (sel)
         TCG_SEL_HINT: picked = hint;
         TCG_SEL_STAT: picked = en;
         default:      picked = '0;
      endcase
   end

   generate
      if (NUM_CLK < DATA_W) begin : g_pad
         assign rdata = {{(DATA_W - NUM_CLK){1'b0}}, picked};
      end else begin : g_full
         assign rdata = picked;
      end
   endgenerate
endmodule

// File: rtl/tcg_ctrl.sv
module tcg_ctrl
   import tcg_pkg::*;
#(
   parameter int unsigned NUM_CLK   = TCG_DEF_CLKS,
   parameter int unsigned DATA_W    = TCG_DEF_DATA_W,
   parameter int unsigned ADDR_W    = TCG_DEF_ADDR_W,
   parameter int unsigned HINT_ADDR = TCG_HINT_ADDR,
   parameter int unsigned STAT_ADDR = TCG_STAT_ADDR
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic               low_power,
   input  logic [NUM_CLK-1:0] idle_in,
   output logic [NUM_CLK-1:0] clk_en
);
   localparam logic [ADDR_W-1:0] HintA = ADDR_W'(HINT_ADDR);
   localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_ADDR);

   generate
      if (NUM_CLK < 1 || NUM_CLK > DATA_W) begin : g_bad_clks
         $error("tcg_ctrl: NUM_CLK must lie in 1..DATA_W");
      end
      if (HINT_ADDR == STAT_ADDR) begin : g_bad_addr
         $error("tcg_ctrl: hint and status addresses must differ");
      end
      if (HINT_ADDR >= (1 << ADDR_W) || STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_aw
         $error("tcg_ctrl: register address does not fit ADDR_W");
      end
   endgenerate

   logic [NUM_CLK-1:0] hint_q;
   logic               hint_wr;
   tcg_sel_e           rd_sel;

   assign hint_wr = reg_wr && (reg_addr == HintA);

   always_comb begin
      if (reg_addr == HintA) begin
         rd_sel = TCG_SEL_HINT;
      end else if (reg_addr == StatA) begin
         rd_sel = TCG_SEL_STAT;
      end else begin
         rd_sel = TCG_SEL_NONE;
      end
   end

   tcg_hint_reg #(.NUM_CLK(NUM_CLK), .DATA_W(DATA_W)) u_hint (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (hint_wr),
      .wdata  (reg_wdata),
      .hint_q (hint_q)
   );

   for (genvar i = 0; i < NUM_CLK; i++) begin : g_cell
      tcg_gate_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .low_power (low_power),
         .hint      (hint_q[i]),
         .idle      (idle_in[i]),
         .en_q      (clk_en[i])
      );
   end

   tcg_read_mux #(.NUM_CLK(NUM_CLK), .DATA_W(DATA_W)) u_rd (
      .sel   (rd_sel),
      .hint  (hint_q),
      .en    (clk_en),
      .rdata (reg_rdata)
   );
endmodule

// File: rtl/tcg_ctrl_chk.sv
module tcg_ctrl_chk #(
   parameter int unsigned NUM_CLK   = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned STAT_ADDR = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               low_power,
   input logic [NUM_CLK-1:0] idle_in,
   input logic [NUM_CLK-1:0] hint_q,
   input logic [NUM_CLK-1:0] clk_en,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [DATA_W-1:0]  reg_rdata
);
   // R7: low power clears every enable on the following edge
   p_lowpower_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      low_power |=> (clk_en == '0));

   // R2: a set hint forces the enable on
   p_hint_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !low_power |=> ((clk_en & $past(hint_q)) == $past(hint_q)));

   // R3: cleared hint plus idle turns the clock off
   p_idle_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !low_power |=> ((clk_en & $past(~hint_q & idle_in)) == '0));

   // R4: a busy block keeps a running clock on
   p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !low_power |=> (($past(clk_en & ~hint_q & ~idle_in) & ~clk_en) == '0));

   // R6: an off clock with cleared hint never restarts by itself
   p_stay_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(~clk_en & ~hint_q) & clk_en) == '0));

   // R8: the status location mirrors the enables
   always_comb begin
      if (rst_n && reg_addr == ADDR_W'(STAT_ADDR)) begin
         p_status_mirror_r8: assert (reg_rdata == DATA_W'(clk_en));
      end
   end
endmodule

bind tcg_ctrl tcg_ctrl_chk #(
   .NUM_CLK   (NUM_CLK),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .STAT_ADDR (STAT_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .low_power (low_power),
   .idle_in   (idle_in),
   .hint_q    (hint_q),
   .clk_en    (clk_en),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata)
);

// File: tb/tcg_ctrl_test.sv
`timescale 1ns/1ps
module tcg_ctrl_test;
   localparam int N = 4;
   localparam int NV = 11;
   // vector layout: {hint[3:0], idle[3:0], low_power, expected enables[3:0]}
   localparam logic [12:0] VEC [NV] = '{
      {4'hF, 4'h0, 1'b0, 4'hF},
      {4'h0, 4'h0, 1'b0, 4'hF},
      {4'h0, 4'h3, 1'b0, 4'hC},
      {4'h0, 4'h0, 1'b0, 4'hC},
      {4'h1, 4'h0, 1'b0, 4'hD},
      {4'h0, 4'hF, 1'b0, 4'h0},
      {4'hF, 4'hF, 1'b1, 4'h0},
      {4'hF, 4'hF, 1'b0, 4'hF},
      {4'hA, 4'h5, 1'b0, 4'hA},
      {4'h0, 4'h0, 1'b0, 4'hA},
      {4'h0, 4'hA, 1'b0, 4'h0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = 2'd0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          low_power = 1'b0;
   logic [N-1:0]  idle_in = '0;
   logic [N-1:0]  clk_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tcg_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .low_power (low_power),
      .idle_in   (idle_in),
      .clk_en    (clk_en)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic read_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic write_hint(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 enables in reset", 32'(clk_en), 32'hF);
      read_chk("R1 hint in reset", 2'd0, 32'hF);
      read_chk("R1 status in reset", 2'd1, 32'hF);
      rst_n = 1'b1;

      // table walk: each vector writes the hint, holds idle/lp two edges
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'(VEC[v][12:9]);
         idle_in = VEC[v][8:5]; low_power = VEC[v][4];
         @(negedge clk);
         reg_wr = 1'b0;
         @(negedge clk);
         check($sformatf("R2-R7 vector %0d enables", v), 32'(clk_en), 32'(VEC[v][3:0]));
         read_chk($sformatf("R8 vector %0d status", v), 2'd1, 32'(VEC[v][3:0]));
         read_chk($sformatf("R9 vector %0d hint readback", v), 2'd0, 32'(VEC[v][12:9]));
      end
      low_power = 1'b0; idle_in = '0;

      // R5: busy hold then release on first idle edge
      write_hint(2'd0, 32'hF);
      @(negedge clk);
      check("R2 restart all", 32'(clk_en), 32'hF);
      write_hint(2'd0, 32'h0);
      @(negedge clk);
      check("R4 busy keeps clocks", 32'(clk_en), 32'hF);
      idle_in = 4'b0100;
      #1;
      check("R5 still on before edge", 32'(clk_en), 32'hF);
      @(negedge clk);
      check("R5 off after first idle edge", 32'(clk_en), 32'hB);
      idle_in = 4'b0000;
      @(negedge clk);
      @(negedge clk);
      check("R6 stays off after idle drops", 32'(clk_en), 32'hB);

      // R7: single-edge response to low power
      low_power = 1'b1;
      @(negedge clk);
      check("R7 all off one edge later", 32'(clk_en), 32'h0);
      low_power = 1'b0;
      @(negedge clk);
      check("R6 off clocks stay off after low power", 32'(clk_en), 32'h0);
      write_hint(2'd0, 32'hF);
      @(negedge clk);
      check("R2 hint restarts after low power", 32'(clk_en), 32'hF);

      // R9: decode of other addresses and upper data bits
      idle_in = 4'hF;
      write_hint(2'd1, 32'h0);
      read_chk("R9 status write ignored", 2'd0, 32'hF);
      write_hint(2'd2, 32'h0);
      read_chk("R9 unmapped write ignored", 2'd0, 32'hF);
      @(negedge clk);
      check("R9 enables unchanged", 32'(clk_en), 32'hF);
      write_hint(2'd0, 32'hFFFF_FFF3);
      read_chk("R9 upper data bits dropped", 2'd0, 32'h3);
      @(negedge clk);
      check("R3 idle clocks with cleared hint off", 32'(clk_en), 32'h3);
      read_chk("R8 status upper bits zero", 2'd1, 32'h3);
      read_chk("R9 unmapped read zero", 2'd3, 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule